// File: doc/BRIEF.md
# Shared-Memory Address Collision Arbiter

This block sits between two independent access ports (left and right) of a shared 1K x 8 memory array. Each cycle it compares the two ports' enables and 10-bit addresses. When both ports are enabled at the same location, it marks the port that arrived later as busy and stops that port's writes from reaching the array. The port that settled first goes on without interruption. Arrival is judged in whole clock cycles. A port counts as settled once it has been enabled at its present address for at least one earlier cycle. If both ports arrive in the same cycle, the left port wins by fixed priority.

A mode input selects the arbitrating role or the follower role. In the follower role the block does no arbitration. Both busy outputs stay inactive, and each port's write enable is gated instead by a busy input driven from an external arbiter. All enables and busy signals are active low. Write requests use a read/write line where 0 means write. The qualified write enables going to the array are active high.

Top module: `dpc_collision_arb`

## Requirements
- R1: After reset is released, and before any collision has been seen, both busy outputs read 1 and both write enables read 0 while both ports are disabled.
- R2: In arbitrating mode (`follower`=0), if in some cycle either enable is 1 or the two addresses differ, both busy outputs read 1 from the following cycle on.
- R3: In arbitrating mode, the port that was already enabled at its current address in the previous cycle is the first arrival. If only one port is a first arrival when the addresses come to match, the other port's busy output goes to 0 one cycle after the match appears.
- R4: If neither port, or both ports, count as first arrivals when a match begins, the right port's busy output goes to 0 and the left port's stays 1.
- R5: While the match holds on consecutive cycles in arbitrating mode, the port chosen as busy does not change, even if the other port becomes settled.
- R6: A busy output returns to 1 in the cycle after the match ends, whether the match ends because a port is disabled or because an address changes.
- R7: The two busy outputs are never 0 at the same time.
- R8: In arbitrating mode, a port's write enable is 1 exactly when its enable is 0, its read/write line is 0 and its own busy output is 1.
- R9: In follower mode (`follower`=1), both busy outputs read 1. A port's write enable is 1 exactly when its enable is 0, its read/write line is 0 and its busy input is 1.
- R10: The comparison covers all 10 address bits. Addresses that differ only in bit 9 do not collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| follower | input | 1 | 1 selects follower mode, 0 selects arbitrating mode |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left read/write, 0 = write |
| l_addr | input | 10 | Left port address |
| l_busy_in_n | input | 1 | Left busy input, used in follower mode |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right read/write, 0 = write |
| r_addr | input | 10 | Right port address |
| r_busy_in_n | input | 1 | Right busy input, used in follower mode |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_en | output | 1 | Qualified left write enable to the array |
| r_wr_en | output | 1 | Qualified right write enable to the array |

## Verification
Two events can fall in the same cycle: a write request and a busy assertion on that same port. When they coincide, the write gate has to follow the busy flag rather than the bare request. The bench provokes this with directed collisions in which the later port holds its read/write line at 0, and with a long random phase over only four addresses, so matches, ties and writes overlap often. A cycle-level behavioural model predicts both busy flags and both write enables, and every cycle the design is judged against that model and against the rule that the two busy flags are never 0 together.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // Which port, if any, currently holds the busy flag.
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } busy_own_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/dpc_arrival_track.sv
// Registers one port's enable and address to tell whether the port
// was already sitting at its current location in the previous cycle.
module dpc_arrival_track #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    en_d   = ~en_n;
    addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end

  // The bit clears as soon as the port is disabled or moves to a new address.
  assign settled = en_q & ~en_n & (addr_q == addr);
endmodule

// File: rtl/dpc_match_detect.sv
module dpc_match_detect #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              a_en_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en_n,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = a_addr ^ b_addr;
    hit  = ~a_en_n & ~b_en_n & ~(|diff);
  end
endmodule

// File: rtl/dpc_busy_fsm.sv
module dpc_busy_fsm
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic follower,
  input  logic hit,
  input  logic l_settled,
  input  logic r_settled,
  output logic l_busy_n,
  output logic r_busy_n
);
  busy_own_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    if (follower || !hit) begin
      own_d = OWN_NONE;
    end else if (own_q == OWN_NONE) begin
      if (l_settled && !r_settled)      own_d = OWN_RIGHT;
      else if (r_settled && !l_settled) own_d = OWN_LEFT;
      else                              own_d = OWN_RIGHT;  // tie: left has priority
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign l_busy_n = follower | (own_q != OWN_LEFT);
  assign r_busy_n = follower | (own_q != OWN_RIGHT);
endmodule

// File: rtl/dpc_write_gate.sv
module dpc_write_gate (
  input  logic follower,
  input  logic en_n,
  input  logic wr_n,
  input  logic own_busy_n,
  input  logic ext_busy_n,
  output logic wr_en
);
  logic blk_n;

  always_comb begin
    blk_n = follower ? ext_busy_n : own_busy_n;
    wr_en = ~en_n & ~wr_n & blk_n;
  end
endmodule

// File: rtl/dpc_collision_arb.sv
module dpc_collision_arb
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              follower,
  input  logic              l_en_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_in_n,
  input  logic              r_en_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic              en_n_a   [NUM_PORTS];
  logic              wr_n_a   [NUM_PORTS];
  logic [ADDR_W-1:0] addr_a   [NUM_PORTS];
  logic              ext_b_a  [NUM_PORTS];
  logic              busy_a   [NUM_PORTS];
  logic              settled_a[NUM_PORTS];
  logic              wr_en_a  [NUM_PORTS];
  logic              hit;

  always_comb begin
    en_n_a[PORT_L]  = l_en_n;       en_n_a[PORT_R]  = r_en_n;
    wr_n_a[PORT_L]  = l_wr_n;       wr_n_a[PORT_R]  = r_wr_n;
    addr_a[PORT_L]  = l_addr;       addr_a[PORT_R]  = r_addr;
    ext_b_a[PORT_L] = l_busy_in_n;  ext_b_a[PORT_R] = r_busy_in_n;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpc_arrival_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_n    (en_n_a[p]),
      .addr    (addr_a[p]),
      .settled (settled_a[p])
    );

    dpc_write_gate u_gate (
      .follower   (follower),
      .en_n       (en_n_a[p]),
      .wr_n       (wr_n_a[p]),
      .own_busy_n (busy_a[p]),
      .ext_busy_n (ext_b_a[p]),
      .wr_en      (wr_en_a[p])
    );
  end

  dpc_match_detect #(.ADDR_W(ADDR_W)) u_match (
    .a_en_n (l_en_n),
    .a_addr (l_addr),
    .b_en_n (r_en_n),
    .b_addr (r_addr),
    .hit    (hit)
  );

  dpc_busy_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .follower  (follower),
    .hit       (hit),
    .l_settled (settled_a[PORT_L]),
    .r_settled (settled_a[PORT_R]),
    .l_busy_n  (busy_a[PORT_L]),
    .r_busy_n  (busy_a[PORT_R])
  );

  assign l_busy_n = busy_a[PORT_L];
  assign r_busy_n = busy_a[PORT_R];
  assign l_wr_en  = wr_en_a[PORT_L];
  assign r_wr_en  = wr_en_a[PORT_R];
endmodule

// File: rtl/dpc_collision_arb_chk.sv
module dpc_collision_arb_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              follower,
  input logic              l_en_n,
  input logic              l_wr_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in_n,
  input logic              r_en_n,
  input logic              r_wr_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_en,
  input logic              r_wr_en
);
  logic same_loc;
  assign same_loc = !l_en_n && !r_en_n && (l_addr == r_addr);

  // R7
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R2
  no_match_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower && !same_loc) |=> (l_busy_n && r_busy_n));

  // R5
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower && same_loc && !l_busy_n) ##1 (!follower && same_loc) |-> !l_busy_n);

  // R5
  hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!follower && same_loc && !r_busy_n) ##1 (!follower && same_loc) |-> !r_busy_n);

  // R8
  left_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !follower |-> (l_wr_en == (!l_en_n && !l_wr_n && l_busy_n)));

  // R8
  right_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !follower |-> (r_wr_en == (!r_en_n && !r_wr_n && r_busy_n)));

  // R9
  follower_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    follower |-> (l_busy_n && r_busy_n &&
                  (l_wr_en == (!l_en_n && !l_wr_n && l_busy_in_n)) &&
                  (r_wr_en == (!r_en_n && !r_wr_n && r_busy_in_n))));
endmodule

bind dpc_collision_arb dpc_collision_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpc_collision_arb_tb.sv
`timescale 1ns/1ps
module dpc_collision_arb_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic follower;
  logic l_en_n, l_wr_n, l_busy_in_n, r_en_n, r_wr_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_own;            // 0 none, 1 left busy, 2 right busy
  bit pl_en, pr_en;
  int pl_addr, pr_addr;

  always #10 clk = ~clk;  // 50 MHz

  dpc_collision_arb #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .follower(follower),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_lbusy_n();
    return follower ? 1'b1 : (m_own != 1);
  endfunction
  function automatic bit m_rbusy_n();
    return follower ? 1'b1 : (m_own != 2);
  endfunction

  task automatic compare_model();
    bit lb, rb, lw, rw;
    lb = m_lbusy_n();
    rb = m_rbusy_n();
    lw = !l_en_n && !l_wr_n && (follower ? l_busy_in_n : lb);
    rw = !r_en_n && !r_wr_n && (follower ? r_busy_in_n : rb);
    chk("R3 model l_busy_n", l_busy_n, lb);
    chk("R3 model r_busy_n", r_busy_n, rb);
    chk("R8 model l_wr_en", l_wr_en, lw);
    chk("R8 model r_wr_en", r_wr_en, rw);
    chk("R7 busy exclusive", !(!l_busy_n && !r_busy_n), 1'b1);
  endtask

  task automatic model_edge();
    bit lon, ron, match, lold, rold;
    lon = !l_en_n; ron = !r_en_n;
    match = lon && ron && (l_addr == r_addr);
    lold = lon && pl_en && (int'(l_addr) == pl_addr);
    rold = ron && pr_en && (int'(r_addr) == pr_addr);
    if (follower || !match) m_own = 0;
    else if (m_own == 0) begin
      if (lold && !rold)      m_own = 2;
      else if (rold && !lold) m_own = 1;
      else                    m_own = 2;
    end
    pl_en = lon; pl_addr = int'(l_addr);
    pr_en = ron; pr_addr = int'(r_addr);
  endtask

  // Drive at the falling edge, compare with the model, then advance the model.
  task automatic step(input bit fol, input bit le, input bit lw, input int la, input bit lbi,
                      input bit re, input bit rw, input int ra, input bit rbi);
    @(negedge clk);
    follower = fol;
    l_en_n = !le; l_wr_n = lw; l_addr = AW'(la); l_busy_in_n = lbi;
    r_en_n = !re; r_wr_n = rw; r_addr = AW'(ra); r_busy_in_n = rbi;
    #1;
    compare_model();
    @(posedge clk);
    model_edge();
    #2;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    follower = 0; l_en_n = 1; l_wr_n = 1; l_addr = '0; l_busy_in_n = 1;
    r_en_n = 1; r_wr_n = 1; r_addr = '0; r_busy_in_n = 1;
    m_own = 0; pl_en = 0; pr_en = 0; pl_addr = 0; pr_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 l_busy_n", l_busy_n, 1'b1);
    chk("R1 r_busy_n", r_busy_n, 1'b1);
    chk("R1 l_wr_en", l_wr_en, 1'b0);
    chk("R1 r_wr_en", r_wr_en, 1'b0);

    // R3 left settles first, right arrives later and tries to write
    step(0, 1,1,5,1, 0,1,0,1);
    step(0, 1,1,5,1, 1,0,5,1);
    chk("R3 right late busy", r_busy_n, 1'b0);
    chk("R3 left keeps", l_busy_n, 1'b1);
    chk("R8 right write blocked", r_wr_en, 1'b0);
    // R6 release by disabling the left port
    step(0, 0,1,5,1, 1,0,5,1);
    chk("R6 release after disable", r_busy_n, 1'b1);
    chk("R8 right write resumes", r_wr_en, 1'b1);

    // R3 right first, then left; R5 hold; R6 release by address change
    step(0, 0,1,0,1, 1,1,9,1);
    step(0, 1,0,9,1, 1,1,9,1);
    chk("R3 left late busy", l_busy_n, 1'b0);
    chk("R8 left write blocked", l_wr_en, 1'b0);
    step(0, 1,0,9,1, 1,1,9,1);
    chk("R5 left still busy", l_busy_n, 1'b0);
    chk("R5 right still free", r_busy_n, 1'b1);
    step(0, 1,0,10,1, 1,1,9,1);
    chk("R6 release after address change", l_busy_n, 1'b1);

    // R4 same-cycle arrival: right loses
    step(0, 0,1,0,1, 0,1,0,1);
    step(0, 1,1,7,1, 1,1,7,1);
    chk("R4 tie right busy", r_busy_n, 1'b0);
    chk("R4 tie left free", l_busy_n, 1'b1);

    // R2 and R10: addresses differ only in bit 9
    step(0, 1,0,12'h005,1, 1,0,12'h205,1);
    step(0, 1,0,12'h005,1, 1,0,12'h205,1);
    chk("R10 no collision on bit 9", r_busy_n & l_busy_n, 1'b1);
    chk("R2 both writes pass", l_wr_en & r_wr_en, 1'b1);

    // R9 follower mode: busy inputs gate writes, busy outputs stay high
    step(1, 1,0,3,0, 1,0,3,1);
    chk("R9 left write held off", l_wr_en, 1'b0);
    chk("R9 right write passes", r_wr_en, 1'b1);
    step(1, 1,0,3,0, 1,0,3,1);
    chk("R9 busy outputs high", l_busy_n & r_busy_n, 1'b1);

    // mixed random traffic on a small address set
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 9) == 0),
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3) != 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule